// File: doc/BRIEF.md
# Adaptive Non-Overlap Half-Bridge Gate Controller

This block is the digital control core of a synchronous buck half-bridge driver. A single PWM input decides which of the two switches should conduct. The block produces a high-side gate enable and a low-side gate enable, and it never lets both conduct at once. Dead time is adaptive. Each turn-on waits for comparator flags that report that the opposite gate has actually discharged, and for the low-side turn-on it also waits for the switch node to have fallen. If the switch node never falls, for example because the high-side switch is shorted, a cycle-count timer forces the low-side switch on anyway.

Three control inputs sit around the commutation sequence. A run input shuts both switches off. A low-side enable holds the synchronous rectifier off when it is low. A clamp input forces the low-side switch on and the high-side switch off, and it overrides every other rule, including supply lockout. All inputs, including the comparator flags and the filtered supply-good flag, pass through two-flop synchronizers. Both outputs are registered.

Top module: `hb_gate_ctrl`

## Requirements
- R1: The high-side and low-side outputs are never both high in the same cycle.
- R2: In steady running operation, meaning run, supply-good and low-side enable high and clamp low, a high PWM gives high-side=1 and low-side=0, and a low PWM gives high-side=0 and low-side=1.
- R3: Timing of a PWM fall, with the input change captured at clock edge 0:
  - The high-side output drops after edge 3.
  - The low-side output rises only after the synchronized switch-node-low and high-side-gate-low flags are both true (flag high means the node or gate is low).
- R4: Every PWM fall restarts a timer of TMO_CYCLES cycles. If the switch-node condition is still missing when the timer expires, the low-side output rises after edge TMO_CYCLES+3, counted from the edge that captured the fall. The flags are ignored in this case.
- R5: On a PWM rise, the low-side output drops after edge 3. The high-side output rises only after the synchronized low-side-gate-low flag is true.
- R6: A PWM rise that arrives while the block is waiting for low-side turn-on cancels the wait and the timer. The low-side output never asserts, and the block proceeds to high-side turn-on.
- R7: When run is low and clamp is low, both outputs are low from edge 2 after the change is captured.
- R8: When low-side enable is low and clamp is low, the low-side output is low from edge 2 after the change is captured. The high-side sequence is unaffected.
- R9: When clamp is high, the outputs are high-side=0 and low-side=1 from edge 2 after the change is captured. This holds whatever the state of run, low-side enable, supply-good and PWM.
- R10: While supply-good is low and clamp is low, both outputs are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM command; high requests high-side conduction |
| run_i | input | 1 | Run enable; low shuts both switches off |
| ls_en_i | input | 1 | Low-side enable; low holds the low-side switch off |
| clamp_i | input | 1 | Overvoltage clamp; high forces the low-side switch on |
| supply_ok_i | input | 1 | Filtered supply-good flag |
| sw_low_i | input | 1 | Comparator flag: switch node below threshold |
| hs_gate_low_i | input | 1 | Comparator flag: high-side gate discharged |
| ls_gate_low_i | input | 1 | Comparator flag: low-side gate discharged |
| hs_on_o | output | 1 | Registered high-side gate enable |
| ls_on_o | output | 1 | Registered low-side gate enable |

## Verification
The in-line assertions check the following on every cycle:
- mutual exclusion of the two outputs;
- the one-cycle effect of clamp, run, low-side enable and supply-good on the output register;
- the timer bound while the block waits for low-side turn-on;
- that a high-side turn-on was preceded by a true low-side-gate-low flag.

Other behaviours appear only in the bench's scenarios, against a flag model that copies the outputs with a delay:
- the exact edge counts of the adaptive dead time;
- the forced low-side turn-on when the switch-node flag is stuck;
- the cancelled wait that must leave the low-side output untouched across a whole window;
- the recovery after each override is released.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  typedef enum logic [2:0] {
    ST_PARK    = 3'd0,
    ST_HS_WAIT = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_LS_WAIT = 3'd3,
    ST_LS_ON   = 3'd4
  } hb_state_e;

  typedef struct packed {
    logic pwm;
    logic run;
    logic ls_en;
    logic clamp;
    logic sup_ok;
    logic sw_low;
    logic hs_gl;
    logic ls_gl;
  } hb_in_t;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("hb_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/hb_deadtime_fsm.sv
module hb_deadtime_fsm
  import hb_gate_pkg::*;
#(
  parameter int TMO_CYCLES = 44
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pwm_i,
  input  logic sw_low_i,
  input  logic hs_gl_i,
  input  logic ls_gl_i,
  output logic hs_req_o,
  output logic ls_req_o
);

  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYCLES - 1);

  hb_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          tmo_hit;

  assign tmo_hit = (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_PARK;
    end else begin
      unique case (state_q)
        ST_PARK:    state_d = pwm_i ? ST_HS_WAIT : ST_LS_WAIT;
        ST_HS_WAIT: if (!pwm_i)      state_d = ST_LS_WAIT;
                    else if (ls_gl_i) state_d = ST_HS_ON;
        ST_HS_ON:   if (!pwm_i)      state_d = ST_LS_WAIT;
        // pwm rise cancels the wait; timer forces turn-on on a stuck switch node
        ST_LS_WAIT: if (pwm_i)       state_d = ST_HS_WAIT;
                    else if ((sw_low_i && hs_gl_i) || tmo_hit) state_d = ST_LS_ON;
        ST_LS_ON:   if (pwm_i)       state_d = ST_HS_WAIT;
        default:    state_d = ST_PARK;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PARK;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_LS_WAIT) cnt_q <= '0;
      else if (!tmo_hit)         cnt_q <= cnt_q + CW'(1);
    end
  end

  assign hs_req_o = (state_q == ST_HS_ON);
  assign ls_req_o = (state_q == ST_LS_ON);

  assert_tmo_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LS_WAIT) |-> (cnt_q <= CNT_LAST));

endmodule

// File: rtl/hb_out_stage.sv
module hb_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ls_en_i,
  input  logic clamp_i,
  input  logic sup_ok_i,
  input  logic hs_req_i,
  input  logic ls_req_i,
  output logic hs_on_o,
  output logic ls_on_o
);

  logic gate_ok;
  logic hs_on_q, ls_on_q;

  assign gate_ok = run_i && sup_ok_i && !clamp_i;

  // clamp outranks run, supply lockout and low-side enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_on_q <= 1'b0;
      ls_on_q <= 1'b0;
    end else begin
      hs_on_q <= gate_ok && hs_req_i;
      ls_on_q <= clamp_i || (gate_ok && ls_en_i && ls_req_i);
    end
  end

  assign hs_on_o = hs_on_q;
  assign ls_on_o = ls_on_q;

  assert_clamp_force_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_i |=> (ls_on_o && !hs_on_o));
  assert_shutdown_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clamp_i) |=> (!hs_on_o && !ls_on_o));
  assert_ls_disable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ls_en_i && !clamp_i) |=> !ls_on_o);
  assert_uvlo_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sup_ok_i && !clamp_i) |=> (!hs_on_o && !ls_on_o));

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TMO_CYCLES  = 44
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic run_i,
  input  logic ls_en_i,
  input  logic clamp_i,
  input  logic supply_ok_i,
  input  logic sw_low_i,
  input  logic hs_gate_low_i,
  input  logic ls_gate_low_i,
  output logic hs_on_o,
  output logic ls_on_o
);

  localparam int IN_W = $bits(hb_in_t);

  hb_in_t raw, syn;
  logic [IN_W-1:0] syn_vec;
  logic hs_req, ls_req, fsm_en;

  assign raw.pwm    = pwm_i;
  assign raw.run    = run_i;
  assign raw.ls_en  = ls_en_i;
  assign raw.clamp  = clamp_i;
  assign raw.sup_ok = supply_ok_i;
  assign raw.sw_low = sw_low_i;
  assign raw.hs_gl  = hs_gate_low_i;
  assign raw.ls_gl  = ls_gate_low_i;

  hb_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn_vec)
  );

  assign syn    = hb_in_t'(syn_vec);
  assign fsm_en = syn.run && syn.sup_ok && !syn.clamp;

  hb_deadtime_fsm #(.TMO_CYCLES(TMO_CYCLES)) fsm_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (fsm_en),
    .pwm_i   (syn.pwm),
    .sw_low_i(syn.sw_low),
    .hs_gl_i (syn.hs_gl),
    .ls_gl_i (syn.ls_gl),
    .hs_req_o(hs_req),
    .ls_req_o(ls_req)
  );

  hb_out_stage out_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (syn.run),
    .ls_en_i (syn.ls_en),
    .clamp_i (syn.clamp),
    .sup_ok_i(syn.sup_ok),
    .hs_req_i(hs_req),
    .ls_req_i(ls_req),
    .hs_on_o (hs_on_o),
    .ls_on_o (ls_on_o)
  );

  assert_no_overlap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_on_o && ls_on_o));
  assert_hs_after_ls_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> $past(syn.ls_gl, 2));

endmodule

// File: tb/hb_gate_ctrl_tb_top.sv
module hb_gate_ctrl_tb_top;

  localparam int TMO      = 20;
  localparam int GATE_DLY = 3;
  localparam int SW_DLY   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, run = 1'b0, ls_en = 1'b1, clamp = 1'b0, ok = 1'b0;
  logic sw_stuck = 1'b0;
  logic hs_on, ls_on;
  logic sw_low, hs_gl, ls_gl;
  logic [GATE_DLY-1:0] hs_sh, ls_sh;
  logic [SW_DLY-1:0]   sw_sh;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int overlaps = 0;
  bit ls_seen = 1'b0;

  typedef struct {
    int    due;
    logic  hs;
    logic  ls;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  hb_gate_ctrl #(.SYNC_STAGES(2), .TMO_CYCLES(TMO)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pwm_i        (pwm),
    .run_i        (run),
    .ls_en_i      (ls_en),
    .clamp_i      (clamp),
    .supply_ok_i  (ok),
    .sw_low_i     (sw_low),
    .hs_gate_low_i(hs_gl),
    .ls_gate_low_i(ls_gl),
    .hs_on_o      (hs_on),
    .ls_on_o      (ls_on)
  );

  // analog model: gate/switch flags are delayed complements of the outputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_sh <= '1;
      ls_sh <= '1;
      sw_sh <= '1;
    end else begin
      hs_sh <= {hs_sh[GATE_DLY-2:0], ~hs_on};
      ls_sh <= {ls_sh[GATE_DLY-2:0], ~ls_on};
      sw_sh <= {sw_sh[SW_DLY-2:0], ~hs_on};
    end
  end
  assign hs_gl  = hs_sh[GATE_DLY-1];
  assign ls_gl  = ls_sh[GATE_DLY-1];
  assign sw_low = sw_sh[SW_DLY-1] & ~sw_stuck;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop due expectations, watch overlap and low-side activity
  always @(negedge clk) begin
    if (hs_on && ls_on) overlaps++;
    if (ls_on) ls_seen = 1'b1;
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t it;
      it = sb_q.pop_front();
      checks++;
      if (hs_on !== it.hs || ls_on !== it.ls) begin
        errors++;
        $display("FAIL %s: hs/ls actual %b%b expected %b%b (cycle %0d)",
                 it.tag, hs_on, ls_on, it.hs, it.ls, cyc);
      end
    end
  end

  task automatic expect_at(int edges, logic hs, logic ls, string tag);
    exp_t it;
    it.due = cyc + 1 + edges;
    it.hs  = hs;
    it.ls  = ls;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    idle(3);
    chk("R1 reset hs", int'(hs_on), 0);
    chk("R1 reset ls", int'(ls_on), 0);
    rst_n = 1'b1;

    // R10 lockout with run high
    run = 1'b1; idle(10);
    expect_at(0, 1'b0, 1'b0, "R10 uvlo pwm low"); idle(2);
    pwm = 1'b1; idle(10);
    expect_at(0, 1'b0, 1'b0, "R10 uvlo pwm high"); idle(2);

    // R9 clamp during lockout and shutdown
    run = 1'b0; pwm = 1'b0; idle(4);
    clamp = 1'b1;
    expect_at(1, 1'b0, 1'b0, "R9 clamp not yet");
    expect_at(2, 1'b0, 1'b1, "R9 clamp forces low side");
    idle(8);
    clamp = 1'b0; idle(8);
    expect_at(0, 1'b0, 1'b0, "R10 clamp released"); idle(2);

    // R2 running, pwm low
    run = 1'b1; ok = 1'b1; idle(30);
    expect_at(0, 1'b0, 1'b1, "R2 pwm low steady"); idle(2);

    // R5 pwm rise
    pwm = 1'b1;
    expect_at(2, 1'b0, 1'b1, "R5 ls still on");
    expect_at(3, 1'b0, 1'b0, "R5 ls off first");
    expect_at(GATE_DLY + 6, 1'b0, 1'b0, "R5 hs waits for ls gate");
    expect_at(GATE_DLY + 7, 1'b1, 1'b0, "R5 hs on");
    idle(30);
    expect_at(0, 1'b1, 1'b0, "R2 pwm high steady"); idle(2);

    // R3 pwm fall
    pwm = 1'b0;
    expect_at(2, 1'b1, 1'b0, "R3 hs still on");
    expect_at(3, 1'b0, 1'b0, "R3 hs off");
    expect_at(SW_DLY + 6, 1'b0, 1'b0, "R3 ls waits for flags");
    expect_at(SW_DLY + 7, 1'b0, 1'b1, "R3 ls on");
    idle(30);

    // R1 toggling
    for (int i = 0; i < 6; i++) begin
      pwm = ~pwm; idle(17 + 3 * i);
    end
    pwm = 1'b1; idle(30);

    // R4 timeout on stuck switch node
    sw_stuck = 1'b1; idle(2);
    pwm = 1'b0;
    expect_at(TMO + 2, 1'b0, 1'b0, "R4 before timeout");
    expect_at(TMO + 3, 1'b0, 1'b1, "R4 forced ls on");
    idle(TMO + 12);

    // R6 cancelled wait
    pwm = 1'b1; idle(30);
    ls_seen = 1'b0;
    pwm = 1'b0; idle(10);
    pwm = 1'b1; idle(30);
    chk("R6 ls never asserted", int'(ls_seen), 0);
    expect_at(0, 1'b1, 1'b0, "R6 hs resumed"); idle(2);
    sw_stuck = 1'b0;

    // R8 low-side disable
    pwm = 1'b0; idle(30);
    ls_en = 1'b0;
    expect_at(1, 1'b0, 1'b1, "R8 ls before disable");
    expect_at(2, 1'b0, 1'b0, "R8 ls held off");
    idle(6);
    pwm = 1'b1; idle(30);
    expect_at(0, 1'b1, 1'b0, "R8 hs unaffected"); idle(2);
    pwm = 1'b0; idle(30);
    expect_at(0, 1'b0, 1'b0, "R8 ls stays off"); idle(2);
    ls_en = 1'b1;
    expect_at(2, 1'b0, 1'b1, "R8 ls re-enabled");
    idle(6);

    // R7 shutdown
    pwm = 1'b1; idle(30);
    run = 1'b0;
    expect_at(1, 1'b1, 1'b0, "R7 before shutdown");
    expect_at(2, 1'b0, 1'b0, "R7 both off");
    idle(8);
    run = 1'b1; idle(30);
    expect_at(0, 1'b1, 1'b0, "R7 restart"); idle(2);

    // R9 clamp overrides running state and other inputs
    clamp = 1'b1;
    expect_at(2, 1'b0, 1'b1, "R9 clamp while hs on");
    idle(4);
    ls_en = 1'b0; run = 1'b0; ok = 1'b0; idle(10);
    expect_at(0, 1'b0, 1'b1, "R9 clamp beats all"); idle(2);
    ls_en = 1'b1; run = 1'b1; ok = 1'b1;
    clamp = 1'b0; idle(30);
    expect_at(0, 1'b1, 1'b0, "R9 clamp released"); idle(2);

    // R10 lockout while running
    ok = 1'b0;
    expect_at(2, 1'b0, 1'b0, "R10 lockout drops hs");
    idle(8);

    chk("R1 overlap cycles", overlaps, 0);
    idle(2);
    finish_run();
  end

endmodule